// File: doc/BRIEF.md
# Store-to-Load Forwarding Queue

This block keeps a small ring of in-flight stores. For each store it holds a word address as the program saw it, the translated word address, a byte-enable mask and the store data. Address and data arrive separately, so each entry has its own address-known and data-known flags. Stores are allocated at the tail in program order and retired from the head.

A load queries the ring with both of its word addresses, its byte mask, a predecoded bit vector that marks the entries older than it, and the ring index of the first store younger than it. In the query cycle the block returns a fast per-byte hit mask and a fast flag saying that some overlapping store still lacks data. One cycle later it returns the resolved result. That result holds a per-byte forward mask with the forwarded bytes, a data-wait flag with the index of the store being waited on, an address-wait flag with the index of the store whose address is unknown, and a translation-mismatch flag.

The query is a valid-qualified stream with no ready. The load pipeline cannot stall, so every valid query is accepted and answered exactly one cycle later. The address-write and data-write ports are likewise accepted on every cycle they are valid, and they apply no back-pressure.

Top module: `sqf_forward_unit`

## Requirements
- R1: After reset the ring is empty, `alloc_ptr` is 0, `rsp_valid` is 0 and `fast_mask` is 0.
- R2: Each allocation takes the entry at `alloc_ptr`. The low bits of `alloc_ptr` are the entry index, its top bit is a wrap flag that toggles each time the index passes the last entry, and it advances by one per allocation. A dequeue retires the oldest entry.
- R3: In the query cycle `fast_mask[b]` is 1 when any older store whose physical word address is known and equal to the load's has lane b set in both masks. `fast_data_inv` is 1 when any such overlapping store lacks data.
- R4: `rsp_valid` and the resolved fields appear exactly one cycle after `q_valid` and describe the queue state in the query cycle. `rsp_mask` is never set on a lane outside the load mask.
- R5: When several older stores write the same lane, the one closest to the load in program order supplies that byte.
- R6: Entries whose bit in `q_older` is 0 take no part in the result.
- R7: A store matches only when its physical word address equals the load's and only on lanes set in both byte masks.
- R8: When the store chosen for some lane lacks data, `rsp_data_inv` is 1 and `rsp_data_inv_idx` is the youngest such chosen store.
- R9: When an older allocated store has no known address, `rsp_addr_inv` is 1 and `rsp_addr_inv_idx` is the youngest such store.
- R10: `rsp_match_inv` is 1 when, among older stores with known address that overlap the load mask, the set matching on virtual word address differs from the set matching on physical word address.
- R11: A lane whose chosen store lacks data has `rsp_mask` 0 even if an older store with data also writes it. The bits of `rsp_data` for lanes with mask 0 are zero.
- R12: A dequeued entry no longer forwards or raises any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocate a store entry at the tail |
| alloc_ptr | output | IDXW+1 | Tail pointer: entry index plus wrap flag |
| deq_req | input | 1 | Retire the head entry |
| addr_wr_valid | input | 1 | Address write strobe |
| addr_wr_idx | input | IDXW | Entry receiving the address |
| addr_wr_vaddr | input | AW | Virtual word address |
| addr_wr_paddr | input | AW | Physical word address |
| addr_wr_mask | input | BYTES | Byte enables |
| data_wr_valid | input | 1 | Data write strobe |
| data_wr_idx | input | IDXW | Entry receiving the data |
| data_wr_data | input | 8*BYTES | Store data, byte b on bits 8b+7:8b |
| q_valid | input | 1 | Load query valid |
| q_vaddr | input | AW | Load virtual word address |
| q_paddr | input | AW | Load physical word address |
| q_mask | input | BYTES | Load byte mask |
| q_older | input | N | One bit per entry older than the load |
| q_ptr | input | IDXW | Entry index of the first store younger than the load |
| fast_mask | output | BYTES | Query-cycle per-lane hit mask |
| fast_data_inv | output | 1 | Query-cycle data-wait hint |
| rsp_valid | output | 1 | Resolved result valid |
| rsp_mask | output | BYTES | Lanes carrying forwarded bytes |
| rsp_data | output | 8*BYTES | Forwarded bytes |
| rsp_data_inv | output | 1 | A chosen store lacks data |
| rsp_data_inv_idx | output | IDXW | Youngest chosen store lacking data |
| rsp_addr_inv | output | 1 | An older store lacks its address |
| rsp_addr_inv_idx | output | IDXW | Youngest older store lacking an address |
| rsp_match_inv | output | 1 | Virtual and physical match sets differ |

## Verification
The assertions assume that no allocation happens while the ring is full and no dequeue while it is empty. They also assume that `q_older` marks only entries between the head and `q_ptr`, with `q_ptr` equal to the tail index when the load was issued, so that program order and distance from `q_ptr` agree. The stimulus tracks the occupancy in a reference model and allocates or dequeues only when that is legal. It always passes the current tail as `q_ptr` and builds `q_older` as a subset of the live entries. Address and data writes go only to live entries.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  typedef struct packed {
    logic used;
    logic addr_ok;
    logic data_ok;
  } sqf_state_t;
endpackage

// File: rtl/sqf_store_array.sv
module sqf_store_array
  import sqf_pkg::*;
#(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int BYTES = 8,
  localparam int IDXW = $clog2(N),
  localparam int DW = 8 * BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_req,
  input  logic                        deq_req,
  input  logic                        addr_wr_valid,
  input  logic [IDXW-1:0]             addr_wr_idx,
  input  logic [AW-1:0]               addr_wr_vaddr,
  input  logic [AW-1:0]               addr_wr_paddr,
  input  logic [BYTES-1:0]            addr_wr_mask,
  input  logic                        data_wr_valid,
  input  logic [IDXW-1:0]             data_wr_idx,
  input  logic [DW-1:0]               data_wr_data,
  output logic [IDXW:0]               head_ptr,
  output logic [IDXW:0]               tail_ptr,
  output sqf_state_t [N-1:0]          st_q,
  output logic [N-1:0][AW-1:0]        vaddr_q,
  output logic [N-1:0][AW-1:0]        paddr_q,
  output logic [N-1:0][BYTES-1:0]     mask_q,
  output logic [N-1:0][DW-1:0]        data_q
);
  wire [IDXW-1:0] tail_idx = tail_ptr[IDXW-1:0];
  wire [IDXW-1:0] head_idx = head_ptr[IDXW-1:0];

  // flags and pointers; later statements win on the same entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      st_q     <= '0;
    end else begin
      if (alloc_req) begin
        st_q[tail_idx] <= '{used: 1'b1, addr_ok: 1'b0, data_ok: 1'b0};
        tail_ptr       <= tail_ptr + 1'b1;
      end
      if (addr_wr_valid) st_q[addr_wr_idx].addr_ok <= 1'b1;
      if (data_wr_valid) st_q[data_wr_idx].data_ok <= 1'b1;
      if (deq_req) begin
        st_q[head_idx] <= '0;
        head_ptr       <= head_ptr + 1'b1;
      end
    end
  end

  // payload carries no reset: qualified by the flags above
  always_ff @(posedge clk) begin
    if (addr_wr_valid) begin
      vaddr_q[addr_wr_idx] <= addr_wr_vaddr;
      paddr_q[addr_wr_idx] <= addr_wr_paddr;
      mask_q[addr_wr_idx]  <= addr_wr_mask;
    end
    if (data_wr_valid) data_q[data_wr_idx] <= data_wr_data;
  end
endmodule

// File: rtl/sqf_match.sv
module sqf_match
  import sqf_pkg::*;
#(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int BYTES = 8
) (
  input  logic                        q_valid,
  input  logic [AW-1:0]               q_vaddr,
  input  logic [AW-1:0]               q_paddr,
  input  logic [BYTES-1:0]            q_mask,
  input  logic [N-1:0]                q_older,
  input  sqf_state_t [N-1:0]          st_q,
  input  logic [N-1:0][AW-1:0]        vaddr_q,
  input  logic [N-1:0][AW-1:0]        paddr_q,
  input  logic [N-1:0][BYTES-1:0]     mask_q,
  output logic [N-1:0]                p_hit,
  output logic [N-1:0]                v_hit,
  output logic [N-1:0]                overlap,
  output logic [N-1:0]                no_addr,
  output logic [BYTES-1:0][N-1:0]     lane_vec
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    wire live = q_valid & st_q[i].used & q_older[i];
    assign p_hit[i]   = live & st_q[i].addr_ok & (paddr_q[i] == q_paddr);
    assign v_hit[i]   = live & st_q[i].addr_ok & (vaddr_q[i] == q_vaddr);
    assign overlap[i] = |(mask_q[i] & q_mask);
    assign no_addr[i] = live & ~st_q[i].addr_ok;
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign lane_vec[b][i] = p_hit[i] & mask_q[i][b] & q_mask[b];
    end
  end
endmodule

// File: rtl/sqf_youngest_pick.sv
module sqf_youngest_pick #(
  parameter int N = 8,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    vec,
  input  logic [IDXW-1:0] base,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  // distance 0 is the entry just before base; smallest distance wins
  always_comb begin
    logic [IDXW-1:0] pos;
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = base - IDXW'(1) - IDXW'(k);
      if (vec[pos]) begin
        hit = 1'b1;
        idx = pos;
      end
    end
  end
endmodule

// File: rtl/sqf_forward_unit.sv
module sqf_forward_unit
  import sqf_pkg::*;
#(
  parameter int N = 8,
  parameter int AW = 16,
  parameter int BYTES = 8,
  localparam int IDXW = $clog2(N),
  localparam int DW = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  output logic [IDXW:0]     alloc_ptr,
  input  logic              deq_req,
  input  logic              addr_wr_valid,
  input  logic [IDXW-1:0]   addr_wr_idx,
  input  logic [AW-1:0]     addr_wr_vaddr,
  input  logic [AW-1:0]     addr_wr_paddr,
  input  logic [BYTES-1:0]  addr_wr_mask,
  input  logic              data_wr_valid,
  input  logic [IDXW-1:0]   data_wr_idx,
  input  logic [DW-1:0]     data_wr_data,
  input  logic              q_valid,
  input  logic [AW-1:0]     q_vaddr,
  input  logic [AW-1:0]     q_paddr,
  input  logic [BYTES-1:0]  q_mask,
  input  logic [N-1:0]      q_older,
  input  logic [IDXW-1:0]   q_ptr,
  output logic [BYTES-1:0]  fast_mask,
  output logic              fast_data_inv,
  output logic              rsp_valid,
  output logic [BYTES-1:0]  rsp_mask,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_data_inv,
  output logic [IDXW-1:0]   rsp_data_inv_idx,
  output logic              rsp_addr_inv,
  output logic [IDXW-1:0]   rsp_addr_inv_idx,
  output logic              rsp_match_inv
);
  logic [IDXW:0]              head_ptr;
  sqf_state_t [N-1:0]         st_q;
  logic [N-1:0][AW-1:0]       vaddr_q, paddr_q;
  logic [N-1:0][BYTES-1:0]    mask_q;
  logic [N-1:0][DW-1:0]       data_q;

  sqf_store_array #(.N(N), .AW(AW), .BYTES(BYTES)) i_array (
    .clk, .rst_n, .alloc_req, .deq_req,
    .addr_wr_valid, .addr_wr_idx, .addr_wr_vaddr, .addr_wr_paddr, .addr_wr_mask,
    .data_wr_valid, .data_wr_idx, .data_wr_data,
    .head_ptr, .tail_ptr(alloc_ptr), .st_q, .vaddr_q, .paddr_q, .mask_q, .data_q
  );

  logic [N-1:0]            p_hit, v_hit, overlap, no_addr;
  logic [BYTES-1:0][N-1:0] lane_vec;

  sqf_match #(.N(N), .AW(AW), .BYTES(BYTES)) i_match (
    .q_valid, .q_vaddr, .q_paddr, .q_mask, .q_older,
    .st_q, .vaddr_q, .paddr_q, .mask_q,
    .p_hit, .v_hit, .overlap, .no_addr, .lane_vec
  );

  // stage one: per-lane youngest writer
  logic [BYTES-1:0]           lane_hit, full_mask;
  logic [BYTES-1:0][IDXW-1:0] lane_idx;
  logic [DW-1:0]              full_data;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    sqf_youngest_pick #(.N(N)) i_pick (
      .vec(lane_vec[b]), .base(q_ptr), .hit(lane_hit[b]), .idx(lane_idx[b])
    );
    assign full_mask[b]        = lane_hit[b] & st_q[lane_idx[b]].data_ok;
    assign full_data[8*b +: 8] = full_mask[b] ? data_q[lane_idx[b]][8*b +: 8] : 8'h00;
  end

  logic [N-1:0] chosen, data_ok_vec;
  always_comb begin
    chosen = '0;
    for (int b = 0; b < BYTES; b++)
      if (lane_hit[b]) chosen[lane_idx[b]] = 1'b1;
    for (int i = 0; i < N; i++) data_ok_vec[i] = st_q[i].data_ok;
  end

  logic            dw_hit, aw_hit;
  logic [IDXW-1:0] dw_idx, aw_idx;

  sqf_youngest_pick #(.N(N)) i_pick_data (
    .vec(chosen & ~data_ok_vec), .base(q_ptr), .hit(dw_hit), .idx(dw_idx)
  );
  sqf_youngest_pick #(.N(N)) i_pick_addr (
    .vec(no_addr), .base(q_ptr), .hit(aw_hit), .idx(aw_idx)
  );

  wire mismatch = |((p_hit & overlap) ^ (v_hit & overlap));

  assign fast_mask     = lane_hit;
  assign fast_data_inv = |(p_hit & overlap & ~data_ok_vec);

  // stage two: registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid        <= 1'b0;
      rsp_mask         <= '0;
      rsp_data         <= '0;
      rsp_data_inv     <= 1'b0;
      rsp_data_inv_idx <= '0;
      rsp_addr_inv     <= 1'b0;
      rsp_addr_inv_idx <= '0;
      rsp_match_inv    <= 1'b0;
    end else begin
      rsp_valid        <= q_valid;
      rsp_mask         <= full_mask;
      rsp_data         <= full_data;
      rsp_data_inv     <= dw_hit;
      rsp_data_inv_idx <= dw_idx;
      rsp_addr_inv     <= aw_hit;
      rsp_addr_inv_idx <= aw_idx;
      rsp_match_inv    <= mismatch;
    end
  end
endmodule

// File: rtl/sqf_forward_checker.sv
module sqf_forward_checker #(
  parameter int N = 8,
  parameter int BYTES = 8,
  localparam int IDXW = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             deq_req,
  input logic [IDXW:0]    head_ptr,
  input logic [IDXW:0]    tail_ptr,
  input logic             q_valid,
  input logic [BYTES-1:0] q_mask,
  input logic [N-1:0]     q_older,
  input logic [BYTES-1:0] fast_mask,
  input logic             fast_data_inv,
  input logic             rsp_valid,
  input logic [BYTES-1:0] rsp_mask,
  input logic             rsp_data_inv,
  input logic             rsp_addr_inv,
  input logic             rsp_match_inv
);
  wire ring_full  = (head_ptr[IDXW] != tail_ptr[IDXW]) &&
                    (head_ptr[IDXW-1:0] == tail_ptr[IDXW-1:0]);
  wire ring_empty = (head_ptr == tail_ptr);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !ring_full);
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    deq_req |-> !ring_empty);
  a_r4_rsp_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> rsp_valid);
  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !rsp_valid);
  a_r4_mask_within_load: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> ((rsp_mask & ~$past(q_mask)) == '0));
  a_r3_fast_covers_full: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> ((rsp_mask & ~$past(fast_mask)) == '0));
  a_r8_fast_hints_data_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !fast_data_inv) |=> !rsp_data_inv);
  a_r9_addr_wait_needs_older: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_inv |-> ($past(q_older) != '0));
  a_r10_mismatch_only_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_match_inv |-> rsp_valid);
endmodule

bind sqf_forward_unit sqf_forward_checker #(.N(N), .BYTES(BYTES)) i_sqf_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .deq_req(deq_req),
  .head_ptr(head_ptr), .tail_ptr(alloc_ptr),
  .q_valid(q_valid), .q_mask(q_mask), .q_older(q_older),
  .fast_mask(fast_mask), .fast_data_inv(fast_data_inv),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_data_inv(rsp_data_inv),
  .rsp_addr_inv(rsp_addr_inv), .rsp_match_inv(rsp_match_inv)
);

// File: tb/test_sqf_forward_unit.sv
module test_sqf_forward_unit;
  localparam int N = 8, AW = 16, BYTES = 8, IDXW = 3, DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic alloc_req = 0, deq_req = 0, addr_wr_valid = 0, data_wr_valid = 0, q_valid = 0;
  logic [IDXW:0] alloc_ptr;
  logic [IDXW-1:0] addr_wr_idx = 0, data_wr_idx = 0, q_ptr = 0;
  logic [AW-1:0] addr_wr_vaddr = 0, addr_wr_paddr = 0, q_vaddr = 0, q_paddr = 0;
  logic [BYTES-1:0] addr_wr_mask = 0, q_mask = 0, fast_mask, rsp_mask;
  logic [DW-1:0] data_wr_data = 0, rsp_data;
  logic [N-1:0] q_older = 0;
  logic fast_data_inv, rsp_valid, rsp_data_inv, rsp_addr_inv, rsp_match_inv;
  logic [IDXW-1:0] rsp_data_inv_idx, rsp_addr_inv_idx;

  sqf_forward_unit i_sqf_forward_unit (.*);

  typedef struct {
    logic [7:0] fmask, mask; logic [63:0] data;
    logic fdinv, dinv; logic [2:0] didx; logic ainv; logic [2:0] aidx; logic minv;
    string tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;

  // reference model
  logic m_used[N], m_av[N], m_dv[N];
  logic [AW-1:0] m_va[N], m_pa[N];
  logic [7:0] m_mask[N];
  logic [63:0] m_data[N];
  logic [3:0] m_head = 0, m_tail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int count();
    return int'(4'(m_tail - m_head));
  endfunction

  function automatic logic [7:0] live_mask();
    logic [7:0] r = '0;
    for (int i = 0; i < N; i++) r[i] = m_used[i];
    return r;
  endfunction

  // walk oldest to youngest; later writers overwrite a lane
  function automatic exp_t predict(logic [15:0] va, pa, logic [7:0] m, logic [7:0] older);
    exp_t e; int wr[8]; int wk[8]; int best;
    e.fmask = 0; e.mask = 0; e.data = 0; e.fdinv = 0; e.dinv = 0; e.didx = 0;
    e.ainv = 0; e.aidx = 0; e.minv = 0; best = -1;
    for (int b = 0; b < 8; b++) begin wr[b] = -1; wk[b] = -1; end
    for (int k = 0; k < count(); k++) begin
      int i; bit pl, vl, ov;
      i = (int'(m_head[2:0]) + k) % N;
      if (!older[i]) continue;
      if (!m_av[i]) begin e.ainv = 1; e.aidx = 3'(i); continue; end
      pl = (m_pa[i] == pa); vl = (m_va[i] == va); ov = |(m_mask[i] & m);
      if ((pl && ov) != (vl && ov)) e.minv = 1;
      if (pl && ov) begin
        if (!m_dv[i]) e.fdinv = 1;
        for (int b = 0; b < 8; b++)
          if (m_mask[i][b] && m[b]) begin wr[b] = i; wk[b] = k; end
      end
    end
    for (int b = 0; b < 8; b++) begin
      if (wr[b] < 0) continue;
      e.fmask[b] = 1;
      if (m_dv[wr[b]]) begin
        e.mask[b] = 1; e.data[8*b +: 8] = m_data[wr[b]][8*b +: 8];
      end else if (wk[b] > best) begin
        best = wk[b]; e.dinv = 1; e.didx = 3'(wr[b]);
      end
    end
    return e;
  endfunction

  task automatic do_alloc();
    @(negedge clk); alloc_req = 1; #1;
    chk(alloc_ptr == m_tail, "R2", "alloc_ptr", 64'(alloc_ptr), 64'(m_tail));
    @(posedge clk); #1 alloc_req = 0;
    m_used[m_tail[2:0]] = 1; m_av[m_tail[2:0]] = 0; m_dv[m_tail[2:0]] = 0;
    m_tail = m_tail + 1;
  endtask

  task automatic do_deq();
    @(negedge clk); deq_req = 1;
    @(posedge clk); #1 deq_req = 0;
    m_used[m_head[2:0]] = 0; m_av[m_head[2:0]] = 0; m_dv[m_head[2:0]] = 0;
    m_head = m_head + 1;
  endtask

  task automatic do_addr(input int i, input logic [15:0] va, pa, input logic [7:0] m);
    @(negedge clk);
    addr_wr_valid = 1; addr_wr_idx = 3'(i); addr_wr_vaddr = va; addr_wr_paddr = pa; addr_wr_mask = m;
    @(posedge clk); #1 addr_wr_valid = 0;
    m_av[i] = 1; m_va[i] = va; m_pa[i] = pa; m_mask[i] = m;
  endtask

  task automatic do_data(input int i, input logic [63:0] d);
    @(negedge clk); data_wr_valid = 1; data_wr_idx = 3'(i); data_wr_data = d;
    @(posedge clk); #1 data_wr_valid = 0;
    m_dv[i] = 1; m_data[i] = d;
  endtask

  task automatic do_query(input logic [15:0] va, pa, input logic [7:0] m,
                          input logic [7:0] older, input string tag);
    exp_t e;
    @(negedge clk);
    e = predict(va, pa, m, older); e.tag = tag;
    q_valid = 1; q_vaddr = va; q_paddr = pa; q_mask = m; q_older = older; q_ptr = m_tail[2:0];
    #1;
    chk(fast_mask == e.fmask, "R3", {tag, " fast_mask"}, 64'(fast_mask), 64'(e.fmask));
    chk(fast_data_inv == e.fdinv, "R3", {tag, " fast_data_inv"}, 64'(fast_data_inv), 64'(e.fdinv));
    sb.push_back(e);
    @(posedge clk); #1 q_valid = 0;
  endtask

  // monitor: resolved result one cycle after each query
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk(0, "R4", "response without query", 1, 0);
      else begin
        e = sb.pop_front();
        chk(rsp_mask == e.mask, "R4", {e.tag, " rsp_mask"}, 64'(rsp_mask), 64'(e.mask));
        chk(rsp_data == e.data, "R4", {e.tag, " rsp_data"}, rsp_data, e.data);
        chk(rsp_data_inv == e.dinv && (!e.dinv || rsp_data_inv_idx == e.didx), "R8",
            {e.tag, " data wait"}, {rsp_data_inv, rsp_data_inv_idx}, {e.dinv, e.didx});
        chk(rsp_addr_inv == e.ainv && (!e.ainv || rsp_addr_inv_idx == e.aidx), "R9",
            {e.tag, " addr wait"}, {rsp_addr_inv, rsp_addr_inv_idx}, {e.ainv, e.aidx});
        chk(rsp_match_inv == e.minv, "R10", {e.tag, " match_inv"}, 64'(rsp_match_inv), 64'(e.minv));
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [15:0] A = 16'h0040;

  initial begin
    for (int i = 0; i < N; i++) begin m_used[i] = 0; m_av[i] = 0; m_dv[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "rsp_valid", 64'(rsp_valid), 0);
    chk(alloc_ptr == 0, "R1", "alloc_ptr", 64'(alloc_ptr), 0);
    chk(fast_mask == 0, "R1", "fast_mask", 64'(fast_mask), 0);

    // R5 youngest writer, R7 other word excluded
    repeat (3) do_alloc();
    do_addr(0, A, A, 8'h0F);
    do_addr(1, A, A, 8'h3C);
    do_addr(2, A + 1, A + 1, 8'hFF);
    do_data(0, 64'h1111_1111_1111_1111);
    do_data(1, 64'h2222_2222_2222_2222);
    do_data(2, 64'h3333_3333_3333_3333);
    do_query(A, A, 8'hFF, live_mask(), "R5 youngest R7 word");
    do_query(A, A, 8'hC0, live_mask(), "R7 lane disjoint");
    // R6 younger entries ignored
    do_query(A, A, 8'hFF, 8'h01, "R6 subset");
    // R8 / R11 youngest writer without data shadows older data
    do_alloc(); do_addr(3, A, A, 8'hF0);
    do_query(A, A, 8'hFF, live_mask(), "R8 R11 data wait");
    // R9 address unknown
    do_alloc();
    do_query(A, A, 8'h01, live_mask(), "R9 addr wait");
    do_addr(4, A + 2, A + 2, 8'h01);
    // R10 translation mismatch
    do_alloc(); do_addr(5, A + 3, A, 8'h80); do_data(5, 64'hAB00_0000_0000_0000);
    do_query(A, A, 8'h80, live_mask(), "R10 mismatch");
    do_data(3, 64'h4444_4444_4444_4444);
    // R12 retired entries drop out
    do_deq();
    do_query(A, A, 8'h03, live_mask(), "R12 after dequeue");
    repeat (5) do_deq();
    do_query(A, A, 8'hFF, 8'hFF, "R12 empty");

    // random traffic: wraps the ring many times (R2)
    for (int n = 0; n < 4000; n++) begin
      int r, k, i; logic [15:0] pa, va; logic [7:0] m, o;
      r = $urandom % 6;
      pa = 16'(8 + $urandom % 4);
      va = ($urandom % 8 == 0) ? 16'(8 + $urandom % 4) : pa;
      m = 8'($urandom % 255 + 1);
      k = (count() > 0) ? int'($urandom % count()) : 0;
      i = (int'(m_head[2:0]) + k) % N;
      case (r)
        0: if (count() < N) do_alloc();
        1: if (count() > 0) do_addr(i, va, pa, m);
        2: if (count() > 0) do_data(i, {$urandom, $urandom});
        3: if (count() > 2 || ($urandom % 4 == 0 && count() > 0)) do_deq();
        default: begin
          o = live_mask();
          if ($urandom % 4 == 0) o = o & 8'($urandom);
          do_query(va, pa, m, o, "RND R5");
        end
      endcase
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R4", "pending responses", 64'(sb.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule